// File: doc/BRIEF.md
# Strobed Host Bus Interface

This block sits between a host processor's asynchronous, strobe-timed bus and the clocked core of a lookup coprocessor. The host starts each cycle by pulling an active-low chip-enable strobe low. The block brings the strobe into the system clock domain through a short flop chain and finds its falling edge there. On that edge it takes in the direction bit, both active-low chip selects, the address-valid flag, the 13-bit address/control field, the half-word segment select and, for writes, the 32-bit write data. Every selected strobe becomes exactly one single-clock command for the core.

Each command is classified in two ways. The address-valid flag tells a memory address apart from a control code. The direction bit tells a read from a write. A 32-bit write is placed on the low or the high half of a 64-bit word, with a matching half enable. For a read, the block picks one half of the core's 64-bit read word and presents it on the output data lines, together with an output enable for the bidirectional pad. A control code below a configurable threshold names a 32-bit register. If such a code arrives with the upper half selected, the block rejects it and raises an error pulse in place of a command.

Top module: `hbus_front`

## Requirements
- R1: While and right after reset, `cmd_valid`, `cmd_err`, `dq_oe` and `wr_half_en` are all zero.
- R2: A selected, well-formed strobe gives `cmd_valid` high for exactly one clock. The pulse is visible after the (SYNC_STAGES+1)-th rising clock edge counted from the first edge that samples `ce_n` low, and not before.
- R3: The strobe is acted on only when `sel1_n` or `sel2_n` is low at capture. With both selects high there is no `cmd_valid`, no `cmd_err`, no `dq_oe`, and the held command fields keep their previous values.
- R4: `cmd_ctrl` equals the captured `av_n` (0 = memory address, 1 = control code) and `cmd_addr` equals the captured `ac`. `cmd_kind` is {cmd_ctrl, cmd_write}: 00 memory read, 01 memory write, 10 control read, 11 control write.
- R5: `cmd_write` is the inverse of the captured `we_n`. `cmd_wdata` holds the captured `dq_in` for a write and zero for a read.
- R6: During a write command, `wr_half_en` is 2'b01 with the data in `wr_word[31:0]` when the captured `seg` is 0, and 2'b10 with the data in `wr_word[63:32]` when `seg` is 1. The other half of `wr_word` is zero. Outside a write pulse, `wr_half_en` is zero.
- R7: A control code below WIDE_CTRL_BASE is a 32-bit register. Captured with `seg`=1, it gives `cmd_err` for one clock in place of `cmd_valid`, with no half enables and no `dq_oe`. Memory addresses, and control codes at or above WIDE_CTRL_BASE, take either segment without error.
- R8: After a valid selected read, `dq_oe` rises together with `cmd_valid` and stays high while `ce_n` remains low. It drops in the same instant `ce_n` goes high, and it is never high while `ce_n` is high or for a write.
- R9: `dq_out` is `rd_word[31:0]` when the captured `seg` is 0 and `rd_word[63:32]` when it is 1.
- R10: The command fields hold their values between strobes. Changes on the input pins while the strobe stays low after capture do not alter them.
- R11: Holding `ce_n` low for many clocks gives only one command. A new command needs `ce_n` to rise and fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Asynchronous active-low chip-enable strobe |
| we_n | input | 1 | Direction: low = host writes, high = host reads |
| sel1_n | input | 1 | Active-low chip select, first |
| sel2_n | input | 1 | Active-low chip select, second |
| av_n | input | 1 | Low = field is a memory address, high = control code |
| ac | input | 13 | Address/control field |
| seg | input | 1 | Half select: 0 = bits 31:0, 1 = bits 63:32 |
| dq_in | input | 32 | Write data from the pad |
| rd_word | input | 64 | Read word supplied by the core |
| dq_out | output | 32 | Read data toward the pad |
| dq_oe | output | 1 | Pad output enable for `dq_out` |
| cmd_valid | output | 1 | One-clock command pulse |
| cmd_err | output | 1 | One-clock rejected-access pulse |
| cmd_write | output | 1 | Command is a write |
| cmd_ctrl | output | 1 | Command targets control space |
| cmd_kind | output | 2 | {cmd_ctrl, cmd_write} |
| cmd_addr | output | 13 | Captured address/control field |
| cmd_seg | output | 1 | Captured half select |
| cmd_wdata | output | 32 | Captured write data |
| wr_word | output | 64 | Write data placed on the selected half |
| wr_half_en | output | 2 | Per-half write enable |

## Verification
The bench builds the block with SYNC_STAGES at 2 and WIDE_CTRL_BASE lowered to 13'h0100. With the lower threshold, short control codes fall on both sides of the narrow/wide boundary, including the code exactly at the threshold. The two-stage chain fixes the command latency at three edges, and every check is timed to that count. This also lets the bench check the cycle before the pulse and the cycle after it.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int AC_W   = 13;
    localparam int DQ_W   = 32;
    localparam int WORD_W = 2 * DQ_W;
    localparam int HALVES = WORD_W / DQ_W;

    typedef enum logic [1:0] {
        ACC_MEM_RD = 2'b00,
        ACC_MEM_WR = 2'b01,
        ACC_CTL_RD = 2'b10,
        ACC_CTL_WR = 2'b11
    } acc_kind_e;

    // Raw pin values taken at the strobe fall
    typedef struct packed {
        logic            we_n;
        logic            sel1_n;
        logic            sel2_n;
        logic            av_n;
        logic [AC_W-1:0] ac;
        logic            seg;
        logic [DQ_W-1:0] dq;
    } bus_sample_t;

    // Classification of one sampled cycle
    typedef struct packed {
        logic      selected;
        logic      is_write;
        logic      is_control;
        logic      seg_fault;
        acc_kind_e kind;
    } cls_t;

    // Command handed to the core
    typedef struct packed {
        logic            is_write;
        logic            is_control;
        logic [AC_W-1:0] addr;
        logic            seg;
        logic [DQ_W-1:0] wdata;
    } cmd_t;

    function automatic acc_kind_e kind_of(input logic is_ctl, input logic is_wr);
        return acc_kind_e'({is_ctl, is_wr});
    endfunction

    // A control code under the threshold names a 32-bit register
    function automatic logic narrow_target(input logic            is_ctl,
                                           input logic [AC_W-1:0] code,
                                           input logic [AC_W-1:0] base);
        return is_ctl && (code < base);
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
#(
    parameter logic [AC_W-1:0] WIDE_CTRL_BASE = 13'h1000
) (
    input  bus_sample_t smp,
    output cls_t        cls
);
    always_comb begin
        cls            = '0;
        cls.selected   = ~smp.sel1_n | ~smp.sel2_n;
        cls.is_write   = ~smp.we_n;
        cls.is_control = smp.av_n;
        cls.seg_fault  = smp.seg & narrow_target(smp.av_n, smp.ac, WIDE_CTRL_BASE);
        cls.kind       = kind_of(smp.av_n, ~smp.we_n);
    end
endmodule

// File: rtl/hbus_cmd_reg.sv
module hbus_cmd_reg
    import hbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fall,
    input  logic        stb_high,
    input  bus_sample_t smp,
    input  cls_t        cls,
    output cmd_t        cmd,
    output acc_kind_e   kind,
    output logic        cmd_valid,
    output logic        cmd_err,
    output logic        rd_active
);
    logic take;
    assign take = fall & cls.selected;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            kind      <= ACC_MEM_RD;
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
            rd_active <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
            if (take) begin
                cmd.is_write   <= cls.is_write;
                cmd.is_control <= cls.is_control;
                cmd.addr       <= smp.ac;
                cmd.seg        <= smp.seg;
                cmd.wdata      <= cls.is_write ? smp.dq : '0;
                kind           <= cls.kind;
                cmd_valid      <= ~cls.seg_fault;
                cmd_err        <= cls.seg_fault;
            end
            if (take && !cls.is_write && !cls.seg_fault)
                rd_active <= 1'b1;
            else if (stb_high)
                rd_active <= 1'b0;
        end
    end
endmodule

// File: rtl/hbus_steer.sv
module hbus_steer
    import hbus_pkg::*;
(
    input  cmd_t              cmd,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] wr_word,
    output logic [HALVES-1:0] wr_half_en,
    output logic [DQ_W-1:0]   rd_half
);
    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            logic pick;
            assign pick = (cmd.seg == (h != 0));
            assign wr_half_en[h]          = cmd_valid & cmd.is_write & pick;
            assign wr_word[h*DQ_W +: DQ_W] = pick ? cmd.wdata : '0;
        end
    endgenerate

    assign rd_half = cmd.seg ? rd_word[WORD_W-1:DQ_W] : rd_word[DQ_W-1:0];
endmodule

// File: rtl/hbus_front.sv
module hbus_front
    import hbus_pkg::*;
#(
    parameter int              SYNC_STAGES    = 2,
    parameter logic [AC_W-1:0] WIDE_CTRL_BASE = 13'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              sel1_n,
    input  logic              sel2_n,
    input  logic              av_n,
    input  logic [AC_W-1:0]   ac,
    input  logic              seg,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              cmd_valid,
    output logic              cmd_err,
    output logic              cmd_write,
    output logic              cmd_ctrl,
    output logic [1:0]        cmd_kind,
    output logic [AC_W-1:0]   cmd_addr,
    output logic              cmd_seg,
    output logic [DQ_W-1:0]   cmd_wdata,
    output logic [WORD_W-1:0] wr_word,
    output logic [HALVES-1:0] wr_half_en
);
    logic        stb_s;
    logic        stb_prev;
    logic        fall;
    logic        rd_active;
    bus_sample_t smp;
    cls_t        cls;
    cmd_t        cmd;
    acc_kind_e   kind;

    hbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ce_n),
        .q   (stb_s)
    );

    always_ff @(posedge clk) begin
        if (rst) stb_prev <= 1'b1;
        else     stb_prev <= stb_s;
    end

    assign fall = stb_prev & ~stb_s;

    always_comb begin
        smp.we_n   = we_n;
        smp.sel1_n = sel1_n;
        smp.sel2_n = sel2_n;
        smp.av_n   = av_n;
        smp.ac     = ac;
        smp.seg    = seg;
        smp.dq     = dq_in;
    end

    hbus_decode #(.WIDE_CTRL_BASE(WIDE_CTRL_BASE)) u_decode (
        .smp (smp),
        .cls (cls)
    );

    hbus_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .fall      (fall),
        .stb_high  (stb_s),
        .smp       (smp),
        .cls       (cls),
        .cmd       (cmd),
        .kind      (kind),
        .cmd_valid (cmd_valid),
        .cmd_err   (cmd_err),
        .rd_active (rd_active)
    );

    hbus_steer u_steer (
        .cmd        (cmd),
        .cmd_valid  (cmd_valid),
        .rd_word    (rd_word),
        .wr_word    (wr_word),
        .wr_half_en (wr_half_en),
        .rd_half    (dq_out)
    );

    // Pad released the moment the raw strobe goes high
    assign dq_oe     = rd_active & ~ce_n;
    assign cmd_write = cmd.is_write;
    assign cmd_ctrl  = cmd.is_control;
    assign cmd_kind  = kind;
    assign cmd_addr  = cmd.addr;
    assign cmd_seg   = cmd.seg;
    assign cmd_wdata = cmd.wdata;
endmodule

// File: rtl/hbus_front_chk.sv
module hbus_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        ce_n,
    input logic        we_n,
    input logic        sel1_n,
    input logic        sel2_n,
    input logic        cmd_valid,
    input logic        cmd_err,
    input logic        cmd_write,
    input logic [12:0] cmd_addr,
    input logic        dq_oe,
    input logic [1:0]  wr_half_en
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!cmd_valid && !cmd_err && wr_half_en == 2'b00));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_selected_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || cmd_err) |-> $past(!sel1_n || !sel2_n));

    assert_direction_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_write == $past(!we_n)));

    assert_one_half_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write) |-> ($countones(wr_half_en) == 1));

    assert_no_half_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (wr_half_en == 2'b00));

    assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (!cmd_valid && !dq_oe));

    assert_oe_read_only_R8: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!ce_n && !cmd_write));

    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid || cmd_err) |-> $stable(cmd_addr));
endmodule

bind hbus_front hbus_front_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .sel1_n     (sel1_n),
    .sel2_n     (sel2_n),
    .cmd_valid  (cmd_valid),
    .cmd_err    (cmd_err),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .dq_oe      (dq_oe),
    .wr_half_en (wr_half_en)
);

// File: tb/hbus_front_tb.sv
`timescale 1ns/1ps
module hbus_front_tb;
    localparam int          SYNC = 2;
    localparam int          LAT  = SYNC + 1;
    localparam logic [12:0] BASE = 13'h0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, sel1_n = 1'b1, sel2_n = 1'b1, av_n = 1'b0, seg = 1'b0;
    logic [12:0] ac = '0;
    logic [31:0] dq_in = '0;
    logic [63:0] rd_word = '0;
    logic [31:0] dq_out;
    logic        dq_oe, cmd_valid, cmd_err, cmd_write, cmd_ctrl, cmd_seg;
    logic [1:0]  cmd_kind, wr_half_en;
    logic [12:0] cmd_addr;
    logic [31:0] cmd_wdata;
    logic [63:0] wr_word;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hbus_front #(.SYNC_STAGES(SYNC), .WIDE_CTRL_BASE(BASE)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .sel1_n(sel1_n), .sel2_n(sel2_n),
        .av_n(av_n), .ac(ac), .seg(seg), .dq_in(dq_in), .rd_word(rd_word),
        .dq_out(dq_out), .dq_oe(dq_oe), .cmd_valid(cmd_valid), .cmd_err(cmd_err),
        .cmd_write(cmd_write), .cmd_ctrl(cmd_ctrl), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .cmd_seg(cmd_seg), .cmd_wdata(cmd_wdata), .wr_word(wr_word), .wr_half_en(wr_half_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a cycle, then stop at the negedge where the pulse should be seen
    task automatic strobe(input logic w, input logic s1, input logic s2, input logic a,
                          input logic [12:0] code, input logic sg, input logic [31:0] d);
        @(negedge clk);
        we_n = w; sel1_n = s1; sel2_n = s2; av_n = a; ac = code; seg = sg; dq_in = d;
        ce_n = 1'b0;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 no early pulse", {62'd0, cmd_valid, cmd_err}, 64'd0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_ce();
        @(negedge clk);
        ce_n = 1'b1;
        repeat (SYNC + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 valid", {63'd0, cmd_valid}, 64'd0);
        chk("R1 err", {63'd0, cmd_err}, 64'd0);
        chk("R1 oe", {63'd0, dq_oe}, 64'd0);
        chk("R1 half_en", {62'd0, wr_half_en}, 64'd0);
    endtask

    task automatic t_mem_write_low();
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 13'h0123, 1'b0, 32'hA5A5_0001);
        chk("R2 pulse", {63'd0, cmd_valid}, 64'd1);
        chk("R5 write", {63'd0, cmd_write}, 64'd1);
        chk("R4 ctrl", {63'd0, cmd_ctrl}, 64'd0);
        chk("R4 addr", {51'd0, cmd_addr}, 64'h123);
        chk("R4 kind", {62'd0, cmd_kind}, 64'd1);
        chk("R5 wdata", {32'd0, cmd_wdata}, 64'hA5A5_0001);
        chk("R6 half_en", {62'd0, wr_half_en}, 64'd1);
        chk("R6 word", wr_word, 64'h0000_0000_A5A5_0001);
        chk("R8 no oe on write", {63'd0, dq_oe}, 64'd0);
        ac = 13'h1FFF; dq_in = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R2 pulse ends", {63'd0, cmd_valid}, 64'd0);
        chk("R6 half_en idle", {62'd0, wr_half_en}, 64'd0);
        chk("R10 addr held", {51'd0, cmd_addr}, 64'h123);
        chk("R10 wdata held", {32'd0, cmd_wdata}, 64'hA5A5_0001);
        release_ce();
    endtask

    task automatic t_mem_write_high();
        strobe(1'b0, 1'b1, 1'b0, 1'b0, 13'h0ABC, 1'b1, 32'h1234_5678);
        chk("R3 sel2 only", {63'd0, cmd_valid}, 64'd1);
        chk("R6 half_en high", {62'd0, wr_half_en}, 64'd2);
        chk("R6 word high", wr_word, 64'h1234_5678_0000_0000);
        chk("R4 kind memwr", {62'd0, cmd_kind}, 64'd1);
        release_ce();
    endtask

    task automatic t_ctl_read_wide();
        rd_word = 64'h1111_2222_3333_4444;
        strobe(1'b1, 1'b0, 1'b0, 1'b1, 13'h0180, 1'b1, 32'hDEAD_BEEF);
        chk("R2 read pulse", {63'd0, cmd_valid}, 64'd1);
        chk("R4 ctrl", {63'd0, cmd_ctrl}, 64'd1);
        chk("R4 kind ctlrd", {62'd0, cmd_kind}, 64'd2);
        chk("R5 read", {63'd0, cmd_write}, 64'd0);
        chk("R5 wdata zero", {32'd0, cmd_wdata}, 64'd0);
        chk("R6 no half on read", {62'd0, wr_half_en}, 64'd0);
        chk("R8 oe up", {63'd0, dq_oe}, 64'd1);
        chk("R9 high half", {32'd0, dq_out}, 64'h1111_2222);
        repeat (4) @(negedge clk);
        chk("R8 oe held", {63'd0, dq_oe}, 64'd1);
        ce_n = 1'b1;
        #1;
        chk("R8 oe drops", {63'd0, dq_oe}, 64'd0);
        repeat (SYNC + 2) @(negedge clk);
        chk("R8 oe stays low", {63'd0, dq_oe}, 64'd0);
    endtask

    task automatic t_mem_read_low();
        rd_word = 64'h5555_6666_7777_8888;
        strobe(1'b1, 1'b0, 1'b1, 1'b0, 13'h0007, 1'b0, 32'h0);
        chk("R4 kind memrd", {62'd0, cmd_kind}, 64'd0);
        chk("R9 low half", {32'd0, dq_out}, 64'h7777_8888);
        chk("R8 oe mem read", {63'd0, dq_oe}, 64'd1);
        release_ce();
    endtask

    task automatic t_deselect();
        strobe(1'b1, 1'b1, 1'b1, 1'b0, 13'h0055, 1'b0, 32'h0);
        chk("R3 no pulse", {63'd0, cmd_valid}, 64'd0);
        chk("R3 no err", {63'd0, cmd_err}, 64'd0);
        chk("R3 no oe", {63'd0, dq_oe}, 64'd0);
        chk("R3 addr kept", {51'd0, cmd_addr}, 64'h007);
        release_ce();
    endtask

    task automatic t_seg_fault();
        strobe(1'b1, 1'b0, 1'b1, 1'b1, 13'h0010, 1'b1, 32'h0);
        chk("R7 err read", {63'd0, cmd_err}, 64'd1);
        chk("R7 no valid", {63'd0, cmd_valid}, 64'd0);
        chk("R7 no oe", {63'd0, dq_oe}, 64'd0);
        @(negedge clk);
        chk("R7 err one clock", {63'd0, cmd_err}, 64'd0);
        release_ce();
        strobe(1'b0, 1'b0, 1'b1, 1'b1, 13'h00FF, 1'b1, 32'hCAFE_F00D);
        chk("R7 err write", {63'd0, cmd_err}, 64'd1);
        chk("R7 no half", {62'd0, wr_half_en}, 64'd0);
        release_ce();
    endtask

    task automatic t_seg_boundaries();
        strobe(1'b0, 1'b0, 1'b1, 1'b1, 13'h0010, 1'b0, 32'h0000_0042);
        chk("R7 narrow low ok", {62'd0, cmd_valid, cmd_err}, 64'd2);
        chk("R4 kind ctlwr", {62'd0, cmd_kind}, 64'd3);
        release_ce();
        strobe(1'b0, 1'b0, 1'b1, 1'b1, BASE, 1'b1, 32'h0000_0099);
        chk("R7 base wide ok", {62'd0, cmd_valid, cmd_err}, 64'd2);
        chk("R6 base high half", {62'd0, wr_half_en}, 64'd2);
        release_ce();
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 13'h0010, 1'b1, 32'h0000_0077);
        chk("R7 memory any half", {62'd0, cmd_valid, cmd_err}, 64'd2);
        release_ce();
    endtask

    task automatic t_one_per_fall();
        int pulses;
        pulses = 0;
        @(negedge clk);
        we_n = 1'b0; sel1_n = 1'b0; sel2_n = 1'b1; av_n = 1'b0; ac = 13'h0333; seg = 1'b0;
        ce_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (cmd_valid) pulses++;
        end
        chk("R11 single command", 64'(pulses), 64'd1);
        release_ce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mem_write_low();
        t_mem_write_high();
        t_ctl_read_wide();
        t_mem_read_low();
        t_deselect();
        t_seg_fault();
        t_seg_boundaries();
        t_one_per_fall();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule